// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an 8-bit successive-approximation converter in a small microcontroller. Software reaches it through a byte-wide bus with an address, write data, read data and separate write and read strobes. It presents two registers: a control/status byte and a read-only result byte. The block drives a trial code to an external DAC and comparator and reads back one comparator bit, `cmp_hi`, which is 1 when the analog input is at or above the trial code. When a conversion ends it sets a done flag. Optionally it raises a level interrupt.

A conversion runs through a small state machine with three states:

- **SEQ_IDLE** waits.
- **SEQ_SAMPLE** spends one cycle holding the DAC at zero while the input settles.
- **SEQ_DECIDE** spends eight cycles, MSB first, setting the next trial bit and keeping or clearing the current one from the comparator.

The state transitions are:

- **start** (any state to SEQ_SAMPLE) is an accepted start write.
- **settle** (SEQ_SAMPLE to SEQ_DECIDE) happens on its own after one cycle.
- **step** (SEQ_DECIDE to SEQ_DECIDE) happens while bits remain.
- **finish** (SEQ_DECIDE to SEQ_IDLE) happens on the last bit and captures the result.
- **abort** (any state to SEQ_IDLE) is a write that clears the power-enable bit.

A start that arrives mid-conversion throws the running one away and begins again.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is 0 and `dac_code` is 0x00.
- R2: The result byte is at address 0xD0 and the control byte is at 0xD1. The control byte has interrupt-enable at bit 7, done flag at bit 6, start at bit 5 and power-enable at bit 4. Any other address, or `bus_re` low, gives `bus_rdata` 0x00.
- R3: A write to 0xD1 with bits 5 and 4 both set clears the done flag at that write edge. The done flag then reads 1, and the result is updated, at the 9th rising edge after the write edge.
- R4: The conversion is a binary search, MSB first. `dac_code` is 0x00 in the cycle after the start edge and 0x80 in the cycle after that. Each decision keeps the trial bit when `cmp_hi` is 1. The final result equals the largest code not above the input.
- R5: Start reads back as 0. Bits 3..0 read as 0. Writing bit 6 or bits 3..0 has no effect.
- R6: A start write during a running conversion restarts it. The done flag rises 9 edges after the latest start, and the result reflects the input seen after that start.
- R7: `irq` is 1 exactly while interrupt-enable and the done flag are both 1.
- R8: A start write with bit 4 at 0 is ignored. Clearing bit 4 during a conversion aborts it: the done flag stays 0, the result keeps its old value and `dac_code` returns to 0x00.
- R9: The done flag stays 1 until the next accepted start, including through power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_re | input | 1 | Read strobe, gates read data |
| bus_rdata | output | 8 | Read data, combinational from address |
| dac_code | output | 8 | Trial code to the external DAC |
| cmp_hi | input | 1 | Comparator: input at or above trial code |
| irq | output | 1 | Level interrupt |

## Verification
Read data and `irq` are combinational from the registers, so they are probed in the same cycle in which they are driven. `dac_code` changes one edge after the start edge (0x00) and again one edge later (0x80). The done flag and the result land on the 9th edge after the accepted start write. The bench places a probe just before that edge and one just after it, so a sequence shortened or lengthened by one cycle fails. A scoreboard queue holds each expected value, and the monitor compares it at the falling edge of the probed cycle.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
    localparam int BUS_W  = 8;
    localparam int CONV_W = 8;

    localparam logic [BUS_W-1:0] ADDR_RESULT = 8'hD0;
    localparam logic [BUS_W-1:0] ADDR_CTRL   = 8'hD1;

    localparam int BIT_IEN   = 7;
    localparam int BIT_DONE  = 6;
    localparam int BIT_START = 5;
    localparam int BIT_PWR   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SAMPLE,
        SEQ_DECIDE
    } seq_state_t;
endpackage

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_sar_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic             cmp_hi_i,
    output logic [RES_W-1:0] dac_code_o,
    output logic [RES_W-1:0] res_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] ONE      = RES_W'(1);
    localparam logic [RES_W-1:0] MSB_ONLY = ONE << (RES_W - 1);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);

    seq_state_t       state_q, state_d;
    logic [RES_W-1:0] trial_q, trial_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    logic [RES_W-1:0] cur_mask;
    logic [RES_W-1:0] decided;
    logic             last_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            trial_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            trial_q <= trial_d;
            idx_q   <= idx_d;
        end
    end

    // next-state logic
    always_comb begin
        cur_mask = ONE << idx_q;
        decided  = cmp_hi_i ? trial_q : (trial_q & ~cur_mask);
        last_bit = (idx_q == '0);
        state_d  = state_q;
        trial_d  = trial_q;
        idx_d    = idx_q;
        unique case (state_q)
            SEQ_IDLE: begin
                state_d = SEQ_IDLE;
            end
            SEQ_SAMPLE: begin
                state_d = SEQ_DECIDE;
                trial_d = MSB_ONLY;
                idx_d   = TOP_IDX;
            end
            SEQ_DECIDE: begin
                if (last_bit) begin
                    state_d = SEQ_IDLE;
                    trial_d = '0;
                    idx_d   = '0;
                end else begin
                    trial_d = decided | (cur_mask >> 1);
                    idx_d   = idx_q - IDX_W'(1);
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
        if (abort_i) begin
            state_d = SEQ_IDLE;
            trial_d = '0;
            idx_d   = '0;
        end
        if (start_i) begin
            state_d = SEQ_SAMPLE;
            trial_d = '0;
            idx_d   = '0;
        end
    end

    // outputs
    always_comb begin
        dac_code_o = trial_q;
        res_o      = decided;
        busy_o     = (state_q != SEQ_IDLE);
        done_o     = (state_q == SEQ_DECIDE) && last_bit && !start_i && !abort_i;
    end

    // R3
    sample_to_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SAMPLE && !start_i && !abort_i) |=> (state_q == SEQ_DECIDE));

    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SAMPLE && !start_i && !abort_i) |=> (trial_q == MSB_ONLY));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DECIDE && idx_q != '0 && !start_i && !abort_i)
        |=> (state_q == SEQ_DECIDE && idx_q == IDX_W'($past(idx_q) - IDX_W'(1))));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == SEQ_SAMPLE && trial_q == '0));

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !start_i) |=> (state_q == SEQ_IDLE && trial_q == '0));
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_sar_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             we_i,
    input  logic             re_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] res_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             start_o,
    output logic             abort_o,
    output logic             pwr_o,
    output logic             irq_o
);
    logic             ien_q, pwr_q, done_q;
    logic [RES_W-1:0] result_q;
    logic             ctrl_hit;

    always_comb begin
        ctrl_hit = we_i && (addr_i == ADDR_CTRL);
        start_o  = ctrl_hit && wdata_i[BIT_START] && wdata_i[BIT_PWR];
        abort_o  = ctrl_hit && !wdata_i[BIT_PWR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q    <= 1'b0;
            pwr_q    <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (ctrl_hit) begin
                ien_q <= wdata_i[BIT_IEN];
                pwr_q <= wdata_i[BIT_PWR];
            end
            if (start_o)
                done_q <= 1'b0;
            else if (done_i)
                done_q <= 1'b1;
            if (done_i)
                result_q <= res_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            if (addr_i == ADDR_RESULT) begin
                rdata_o = BUS_W'(result_q);
            end else if (addr_i == ADDR_CTRL) begin
                rdata_o[BIT_IEN]  = ien_q;
                rdata_o[BIT_DONE] = done_q;
                rdata_o[BIT_PWR]  = pwr_q;
            end
        end
        pwr_o = pwr_q;
        irq_o = ien_q && done_q;
    end

    // R3
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done_i));

    // R3
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !done_q);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start_o) |=> done_q);

    // R8
    result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(result_q));
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
    import adc_sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CONV_W-1:0] dac_code,
    input  logic              cmp_hi,
    output logic              irq
);
    logic              start_w, abort_w, done_w, busy_w, pwr_w;
    logic [CONV_W-1:0] res_w;

    adc_ctrl_regs #(.RES_W(CONV_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .we_i    (bus_we),
        .re_i    (bus_re),
        .done_i  (done_w),
        .res_i   (res_w),
        .rdata_o (bus_rdata),
        .start_o (start_w),
        .abort_o (abort_w),
        .pwr_o   (pwr_w),
        .irq_o   (irq)
    );

    adc_sar_seq #(.RES_W(CONV_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .abort_i    (abort_w),
        .cmp_hi_i   (cmp_hi),
        .dac_code_o (dac_code),
        .res_o      (res_w),
        .done_o     (done_w),
        .busy_o     (busy_w)
    );

    // R8
    power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_w |-> !busy_w);
endmodule

// File: tb/tb_adc_sar_ctrl.sv
`timescale 1ns/1ps
module tb_adc_sar_ctrl;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_DAC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] dac_code;
    logic       cmp_hi;
    logic       irq;
    logic [7:0] ain = '0;
    logic       probe = 1'b0;
    int         tests = 0;
    int         fails = 0;
    bit         ended = 0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    assign cmp_hi = (ain >= dac_code);

    adc_sar_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .dac_code  (dac_code),
        .cmp_hi    (cmp_hi),
        .irq       (irq)
    );

    // monitor: compares the oldest expectation in the probed cycle
    always @(negedge clk) begin
        if (probe && sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {7'd0, irq};
                default: act = dac_code;
            endcase
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic strobe, input logic [7:0] exp, input string req);
        push(K_RD, exp, req);
        bus_addr = a;
        bus_re   = strobe;
        probe    = 1'b1;
        @(posedge clk);
        #1;
        bus_re = 1'b0;
        probe  = 1'b0;
    endtask

    task automatic look(input int kind, input logic [7:0] exp, input string req);
        push(kind, exp, req);
        probe = 1'b1;
        @(posedge clk);
        #1;
        probe = 1'b0;
    endtask

    task automatic convert(input logic [7:0] v, input string req);
        ain = v;
        wr(8'hD1, 8'hB0);
        wait_edges(9);
        rd(8'hD0, 1'b1, v, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);

        // R1 reset state
        rd(8'hD1, 1'b1, 8'h00, "R1");
        rd(8'hD0, 1'b1, 8'h00, "R1");
        look(K_IRQ, 8'h00, "R1");
        look(K_DAC, 8'h00, "R1");

        // R2 enable and power on
        wr(8'hD1, 8'h90);
        rd(8'hD1, 1'b1, 8'h90, "R2");

        // R3/R4 first conversion with step-by-step trial codes
        ain = 8'hA5;
        wr(8'hD1, 8'hB0);                  // write edge E0
        look(K_DAC, 8'h00, "R4");          // after E0: sample
        look(K_DAC, 8'h80, "R4");          // after E1
        look(K_DAC, 8'hC0, "R4");          // after E2
        rd(8'hD1, 1'b1, 8'h90, "R5");      // start reads 0, after E3
        wait_edges(4);                     // now after E8
        rd(8'hD1, 1'b1, 8'h90, "R3");      // not yet done
        rd(8'hD1, 1'b1, 8'hD0, "R3");      // after E9: done
        look(K_IRQ, 8'h01, "R7");
        rd(8'hD0, 1'b1, 8'hA5, "R4");

        // R5/R7 reserved bit writes, irq off
        wr(8'hD1, 8'h5F);
        rd(8'hD1, 1'b1, 8'h50, "R5");
        look(K_IRQ, 8'h00, "R7");

        // R3/R5 start clears done; write to done bit mid-run ignored
        ain = 8'h3C;
        wr(8'hD1, 8'hB0);                  // E0
        rd(8'hD1, 1'b1, 8'h90, "R3");      // after E0
        wr(8'hD1, 8'hDF);                  // E2
        rd(8'hD1, 1'b1, 8'h90, "R5");      // after E2
        wait_edges(5);                     // after E8
        rd(8'hD1, 1'b1, 8'h90, "R3");
        rd(8'hD1, 1'b1, 8'hD0, "R3");
        rd(8'hD0, 1'b1, 8'h3C, "R4");

        // R6 restart mid-conversion
        ain = 8'h11;
        wr(8'hD1, 8'hB0);                  // E0
        wait_edges(4);                     // after E4
        ain = 8'hEE;
        wr(8'hD1, 8'hB0);                  // E5
        wait_edges(8);                     // after E13
        rd(8'hD1, 1'b1, 8'h90, "R6");
        rd(8'hD1, 1'b1, 8'hD0, "R6");
        rd(8'hD0, 1'b1, 8'hEE, "R6");

        // R8 power-down abort
        ain = 8'h77;
        wr(8'hD1, 8'hB0);
        wait_edges(3);
        wr(8'hD1, 8'h80);
        look(K_DAC, 8'h00, "R8");
        wait_edges(12);
        rd(8'hD1, 1'b1, 8'h80, "R8");
        rd(8'hD0, 1'b1, 8'hEE, "R8");
        look(K_IRQ, 8'h00, "R8");

        // R8 start while powered down is ignored
        wr(8'hD1, 8'hA0);
        look(K_DAC, 8'h00, "R8");
        wait_edges(12);
        rd(8'hD1, 1'b1, 8'h80, "R8");
        rd(8'hD0, 1'b1, 8'hEE, "R8");

        // R2 unmapped address and missing strobe
        rd(8'h42, 1'b1, 8'h00, "R2");
        rd(8'hD0, 1'b0, 8'h00, "R2");

        // R4 extreme codes
        wr(8'hD1, 8'h90);
        convert(8'h00, "R4");
        convert(8'hFF, "R4");
        convert(8'h01, "R4");

        // R9 done flag survives power-down
        wr(8'hD1, 8'h00);
        rd(8'hD1, 1'b1, 8'h40, "R9");
        look(K_IRQ, 8'h00, "R7");

        wait_edges(2);
        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule